// File: doc/BRIEF.md
# Four-Channel PWM Generator with Register File

This block holds four independent pulse-width channels behind a 32-bit word-addressed register file. Each channel counts down from a programmable period value on each of its tick enables, which a separate prescaler supplies. It drives its output to the active level while the count is at or below a programmable compare value. Software sets the period, compare value, enable, continuous-mode and polarity bits through word writes. It can read back every stored value and the live count of each channel.

A channel runs only when its enable bit and its continuous-mode bit are both set. A stopped channel parks its counter at the period value and shows the inactive level. The invert bit applies to that level as well. The clock-divider and selector words are kept only as storage for the neighbouring prescaler. The interrupt and watchdog-data words are placeholders that read zero.

Top module: `pwm4_regbank`

## Requirements
- R1: After reset every register reads 0 and every PWM output is 0.
- R2: A write of a value above 65535 to a period or compare register stores 65535. Smaller values are stored as written. Channel n has its period at 0x0C+12n and its compare at 0x10+12n.
- R3: A channel runs only when bit 0 (enable) and bit 3 (continuous mode) of its control nibble are both 1. Otherwise its output holds the inactive level, and its counter-data register (0x14+12n) reads the period value.
- R4: A running channel's counter loads the period value. It decrements on each cycle whose tick input is 1, reloads the period after reaching 0, and holds on other cycles. Its counter-data register returns the live count.
- R5: A running channel with period P≥1 and compare C<P is active (output 1 when not inverted) for exactly C+1 of every P+1 ticks.
- R6: A period of 0 gives a constant inactive output. A compare value of P or more with P≥1 gives a constant active output.
- R7: Bit 2 (invert) of the nibble flips output polarity, whether the channel runs or is stopped. Changing it on a running channel leaves the counter value unchanged.
- R8: Channel 0..3 control nibbles sit at bit 0, 8, 12 and 16 of the control word at offset 0x08.
- R9: Writes to counter-data, interrupt-enable (0x3C), interrupt-status (0x40) and watchdog-data (0x44..0x50) registers are ignored. The last three kinds always read 0.
- R10: Reads from undefined offsets or from addresses with nonzero low two bits return 0. Writes to them change nothing.
- R11: The prescale (0x00), selector (0x04) and control (0x08) words read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| chan_tick | input | 4 | Per-channel count enable from the prescaler |
| pwm_out | output | 4 | Per-channel PWM outputs |

## Verification
A wrong count or a wrong reload value shows on the counter-data read-back on the very next tick. Over one full period it also shows as a wrong number of active samples on `pwm_out`, so the bench counts active cycles across P+1 ticks for several period, compare and polarity combinations. A misplaced control nibble or a wrong run condition shows at once as an output stuck at the wrong level, or as a counter that fails to move after a tick. A bad address decode shows on the next read as a nonzero value from a placeholder or as a corrupted neighbouring register.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

   localparam int unsigned REG_W = 32;

   localparam int unsigned OFF_PRESCALE = 'h00;
   localparam int unsigned OFF_SELECT   = 'h04;
   localparam int unsigned OFF_CONTROL  = 'h08;
   localparam int unsigned CH_STRIDE    = 12;

   // control nibble of one channel
   typedef struct packed {
      logic cont;   // bit 3: continuous mode
      logic inv;    // bit 2: polarity flip
      logic rsv;    // bit 1: unused
      logic en;     // bit 0: enable
   } ctl_nib_t;

   function automatic int unsigned nib_pos(int unsigned ch);
      return (ch == 0) ? 0 : 4 + 4 * ch;
   endfunction

   function automatic int unsigned period_off(int unsigned ch);
      return 'h0C + CH_STRIDE * ch;
   endfunction

   function automatic int unsigned compare_off(int unsigned ch);
      return 'h10 + CH_STRIDE * ch;
   endfunction

   function automatic int unsigned count_off(int unsigned ch);
      return 'h14 + CH_STRIDE * ch;
   endfunction

endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
   import pwm4_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [REG_W-1:0]                 wdata,
   output logic [REG_W-1:0]                 rdata,
   input  logic [NUM_CH-1:0][CNT_W-1:0]     cnt_view,
   output logic [NUM_CH-1:0][CNT_W-1:0]     period_o,
   output logic [NUM_CH-1:0][CNT_W-1:0]     compare_o,
   output ctl_nib_t [NUM_CH-1:0]            ctl_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             aligned;
   logic [CNT_W-1:0] wr_clamped;
   logic [REG_W-1:0] prescale_q, select_q, control_q;

   assign aligned    = (addr[1:0] == 2'b00);
   assign wr_clamped = (|wdata[REG_W-1:CNT_W]) ? CNT_MAX : wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prescale_q <= '0;
         select_q   <= '0;
         control_q  <= '0;
      end else if (wr_en && aligned) begin
         if (addr == ADDR_W'(OFF_PRESCALE)) prescale_q <= wdata;
         if (addr == ADDR_W'(OFF_SELECT))   select_q   <= wdata;
         if (addr == ADDR_W'(OFF_CONTROL))  control_q  <= wdata;
      end
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic [CNT_W-1:0] period_q, compare_q;
      logic             hit_per, hit_cmp;

      assign hit_per = wr_en && aligned && (addr == ADDR_W'(period_off(n)));
      assign hit_cmp = wr_en && aligned && (addr == ADDR_W'(compare_off(n)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            period_q  <= '0;
            compare_q <= '0;
         end else begin
            if (hit_per) period_q  <= wr_clamped;
            if (hit_cmp) compare_q <= wr_clamped;
         end
      end

      assign period_o[n]  = period_q;
      assign compare_o[n] = compare_q;
      assign ctl_o[n]     = control_q[nib_pos(n) +: 4];

      // R2: oversize writes saturate
      p_clamp_per_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(period_off(n)) && wdata > REG_W'(CNT_MAX))
         |=> period_o[n] == CNT_MAX);
      p_clamp_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(compare_off(n)) && wdata > REG_W'(CNT_MAX))
         |=> compare_o[n] == CNT_MAX);
   end

   always_comb begin
      rdata = '0;
      if (aligned) begin
         if (addr == ADDR_W'(OFF_PRESCALE)) rdata = prescale_q;
         if (addr == ADDR_W'(OFF_SELECT))   rdata = select_q;
         if (addr == ADDR_W'(OFF_CONTROL))  rdata = control_q;
         for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(period_off(n)))  rdata = REG_W'(period_o[n]);
            if (addr == ADDR_W'(compare_off(n))) rdata = REG_W'(compare_o[n]);
            if (addr == ADDR_W'(count_off(n)))   rdata = REG_W'(cnt_view[n]);
         end
      end
   end

   // R10: a misaligned write leaves the shared words alone
   p_unaligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[1:0] != 2'b00)
      |=> ($stable(control_q) && $stable(prescale_q) && $stable(select_q)));

endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
   import pwm4_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  ctl_nib_t         ctl,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] compare,
   output logic [CNT_W-1:0] cnt_view,
   output logic             pwm
);

   logic             run;
   logic             active;
   logic             pwm_nxt;
   logic [CNT_W-1:0] cnt_q;

   assign run = ctl.en && ctl.cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run)          cnt_q <= period;
      else if (tick) begin
         if (cnt_q == '0)     cnt_q <= period;
         else                 cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign active   = run && (period != '0) && (cnt_q <= compare);
   assign pwm_nxt  = active ^ ctl.inv;
   assign cnt_view = run ? cnt_q : period;

   if (OUT_REG) begin : g_out_flop
      logic pwm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_q <= 1'b0;
         else        pwm_q <= pwm_nxt;
      end
      assign pwm = pwm_q;
   end else begin : g_out_comb
      assign pwm = pwm_nxt;
   end

   // R3: stopped channel sits at the inactive level
   p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> pwm_nxt == ctl.inv);
   // R4: count holds without tick, steps down with tick, reloads at zero
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> cnt_q == $past(cnt_q));
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt_q == '0) |=> cnt_q == $past(period));
   // R6: flat outputs at the extremes
   p_flat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0) |-> pwm_nxt == ctl.inv);
   p_flat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && period != '0 && compare >= period && cnt_q <= period)
      |-> pwm_nxt == !ctl.inv);

endmodule

// File: rtl/pwm4_regbank.sv
module pwm4_regbank
   import pwm4_pkg::*;
#(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned ADDR_W  = 12,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [NUM_CH-1:0] chan_tick,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int unsigned LAST_OFF = count_off(NUM_CH - 1);

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must lie in 1..4 to fit the control word");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
      $error("CNT_W must lie in 2..16");
   end
   if (LAST_OFF >= (1 << ADDR_W)) begin : g_bad_a
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] period, compare, cnt_view;
   ctl_nib_t [NUM_CH-1:0]        ctl;

   pwm4_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .cnt_view  (cnt_view),
      .period_o  (period),
      .compare_o (compare),
      .ctl_o     (ctl)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      pwm4_chan #(
         .CNT_W   (CNT_W),
         .OUT_REG (OUT_REG)
      ) i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (chan_tick[n]),
         .ctl      (ctl[n]),
         .period   (period[n]),
         .compare  (compare[n]),
         .cnt_view (cnt_view[n]),
         .pwm      (pwm_out[n])
      );
   end

endmodule

// File: tb/test_pwm4_regbank.sv
`timescale 1ns/1ps
module test_pwm4_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  chan_tick = '0;
   logic [3:0]  pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm4_regbank i_pwm4_regbank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .chan_tick (chan_tick),
      .pwm_out   (pwm_out)
   );

   // vectors: period, compare, invert  (R5, R6, R7)
   localparam int NV = 8;
   localparam int VP [NV] = '{9, 9, 5, 5, 0, 7, 3, 0};
   localparam int VC [NV] = '{3, 3, 5, 20, 7, 0, 2, 0};
   localparam int VI [NV] = '{0, 1, 0, 0, 0, 0, 1, 1};

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic ticks(input int ch, input int n);
      for (int i = 0; i < n; i++) begin
         chan_tick[ch] = 1'b1;
         @(negedge clk);
         chan_tick[ch] = 1'b0;
      end
   endtask

   initial begin
      logic [31:0] v;
      int hi, base, exp;

      repeat (3) @(negedge clk);
      // R1: reset state
      rd(12'h000, v); check("R1 prescale", v, 0);
      rd(12'h008, v); check("R1 control", v, 0);
      rd(12'h00C, v); check("R1 period0", v, 0);
      rd(12'h034, v); check("R1 compare3", v, 0);
      check("R1 outputs", {28'd0, pwm_out}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 R6 R7: duty over one period, walked from the table
      for (int k = 0; k < NV; k++) begin
         wr(12'h008, 32'h0);
         wr(12'h00C, VP[k]);
         wr(12'h010, VC[k]);
         wr(12'h008, 32'h9 | (VI[k] << 2));
         hi = 0;
         for (int i = 0; i <= VP[k]; i++) begin
            if (pwm_out[0]) hi++;
            chan_tick[0] = 1'b1;
            @(negedge clk);
            chan_tick[0] = 1'b0;
         end
         base = (VP[k] == 0) ? 0 : (VC[k] >= VP[k]) ? VP[k] + 1 : VC[k] + 1;
         exp  = VI[k] ? (VP[k] + 1 - base) : base;
         check($sformatf("R5/R6 vector %0d", k), hi, exp);
      end

      // R2: clamping
      wr(12'h008, 32'h0);
      wr(12'h00C, 32'h0001_2345);
      rd(12'h00C, v); check("R2 period clamp", v, 32'hFFFF);
      wr(12'h010, 32'h0001_0000);
      rd(12'h010, v); check("R2 compare clamp", v, 32'hFFFF);
      wr(12'h010, 32'h0000_FFFF);
      rd(12'h010, v); check("R2 compare max kept", v, 32'hFFFF);

      // R4: live count and wrap
      wr(12'h00C, 4);
      wr(12'h010, 1);
      wr(12'h008, 32'h9);
      ticks(0, 2);
      rd(12'h014, v); check("R4 count after 2 ticks", v, 2);
      ticks(0, 3);
      rd(12'h014, v); check("R4 count after wrap", v, 4);
      repeat (3) @(negedge clk);
      rd(12'h014, v); check("R4 hold without tick", v, 4);

      // R7: live invert keeps the counter
      ticks(0, 2);
      wr(12'h008, 32'hD);
      rd(12'h014, v); check("R7 count kept on invert", v, 2);
      check("R7 inverted level", pwm_out[0], 1);

      // R3: enable alone or continuous alone does not run
      wr(12'h008, 32'h1);
      ticks(0, 3);
      rd(12'h014, v); check("R3 enable only count", v, 4);
      check("R3 enable only output", pwm_out[0], 0);
      wr(12'h008, 32'h8);
      ticks(0, 2);
      rd(12'h014, v); check("R3 cont only count", v, 4);
      wr(12'h008, 32'h4);
      check("R7 stopped inverted", pwm_out[0], 1);

      // R8: nibble placement, channel 2 runs, channel 3 inverted idle
      wr(12'h024, 3);
      wr(12'h028, 1);
      wr(12'h008, 32'h0004_9000);
      check("R8 ch3 idle inverted", pwm_out[3], 1);
      check("R8 ch1 idle", pwm_out[1], 0);
      ticks(2, 1);
      rd(12'h02C, v); check("R8 ch2 counting", v, 2);
      check("R8 ch2 low above compare", pwm_out[2], 0);
      ticks(2, 1);
      check("R8 ch2 high at compare", pwm_out[2], 1);
      check("R8 ch0 stopped", pwm_out[0], 0);

      // R9: ignored writes
      wr(12'h008, 32'h0);
      wr(12'h014, 32'h55);
      rd(12'h014, v); check("R9 counter-data write ignored", v, 4);
      wr(12'h03C, 32'hFFFF_FFFF);
      rd(12'h03C, v); check("R9 irq enable", v, 0);
      wr(12'h040, 32'hFFFF_FFFF);
      rd(12'h040, v); check("R9 irq status", v, 0);
      wr(12'h044, 32'hFFFF_FFFF);
      rd(12'h044, v); check("R9 watchdog first", v, 0);
      wr(12'h050, 32'hFFFF_FFFF);
      rd(12'h050, v); check("R9 watchdog last", v, 0);

      // R10: undefined and misaligned
      wr(12'h00D, 32'h7);
      rd(12'h00C, v); check("R10 misaligned write", v, 4);
      rd(12'h00D, v); check("R10 misaligned read", v, 0);
      wr(12'h054, 32'h1234);
      rd(12'h054, v); check("R10 undefined read", v, 0);
      rd(12'hFFC, v); check("R10 far offset", v, 0);

      // R11: full-word read-back
      wr(12'h000, 32'hA5A5_1234);
      rd(12'h000, v); check("R11 prescale", v, 32'hA5A5_1234);
      wr(12'h004, 32'h0000_4321);
      rd(12'h004, v); check("R11 selector", v, 32'h0000_4321);
      wr(12'h008, 32'hF0F0_0000);
      rd(12'h008, v); check("R11 control", v, 32'hF0F0_0000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule